// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns a 16-bit instruction halfword of a 32-bit, 16-register processor into a flat control bundle for the stages that follow it. The two top bits choose one of three encodings, each with its own field layout. The bundle carries the encoding class, the opcode, the two register indices, an immediate widened to the data width, whether a 32-bit extension word follows the halfword, the instruction length in bytes, a flag for encodings with no defined meaning, a one-hot operation select and the memory access size.

The decoder is purely combinational. Fetching the extension word, executing the operation and holding the register file are left to the surrounding pipeline. The length output is what the fetch logic adds to the program counter, and the one-hot select is what the execution and memory units use.

Top module: `insn_decoder`

## Requirements
- R1: `fmt` is 1 when bit 15 is 0, 2 when bits 15:14 are `10`, and 3 when bits 15:14 are `11`.
- R2: In class 1, `opcode` is bits 15:8, `ra` is bits 7:4, `rb` is bits 3:0, and `imm` is zero.
- R3: In class 2, `opcode` is bits 13:12 zero-extended, `ra` is bits 11:8, `rb` is zero, and `imm` is bits 7:0 zero-extended. The same value selects one of 256 special registers.
- R4: In class 3, `opcode` is the 4-bit condition in bits 13:10, `ra` and `rb` are zero, and `imm` is bits 9:0 sign-extended and then doubled, which gives a byte offset.
- R5: `illegal` is set for class-1 opcodes 0x0F to 0x18, for class-1 opcodes above 0x39, and for class-3 conditions above 9. It is clear for every other encoding, including all four class-2 opcodes.
- R6: `has_ext` is set only for the legal class-1 opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 to 0x39. `len` is 6 when `has_ext` is set and 2 otherwise.
- R7: `op_sel` has exactly one bit set. Bit positions are: 0 none, 1 load-immediate, 2 move, 3 call, 4 return, 5 add, 6 sub, 7 and, 8 or, 9 xor, 10 not, 11 negate, 12 shift-left, 13 logical shift-right, 14 arithmetic shift-right, 15 multiply, 16 signed divide, 17 unsigned divide, 18 signed remainder, 19 unsigned remainder, 20 load, 21 store, 22 push, 23 pop, 24 compare, 25 jump, 26 software interrupt, 27 breakpoint (opcode 0x35), 28 to 31 the class-2 increment, decrement, special-register read and special-register write, and 32 conditional branch. An illegal encoding selects bit 0.
- R8: `mem_size` is 0 for byte accesses (0x1C to 0x1F, 0x36, 0x37) and 1 for halfword accesses (0x21 to 0x24, 0x38, 0x39). It is 2 for word accesses, which are the loads and stores 0x08 to 0x0D, push, pop, both calls (0x03, 0x19) and return (0x04). It is 3 when the encoding makes no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 16 | Instruction halfword |
| fmt | output | 2 | Encoding class 1, 2 or 3 |
| opcode | output | 8 | Opcode or branch condition, zero-extended |
| ra | output | 4 | First register index |
| rb | output | 4 | Second register index |
| imm | output | 32 | Immediate or branch byte offset |
| has_ext | output | 1 | A 32-bit extension word follows |
| len | output | 3 | Instruction length in bytes |
| illegal | output | 1 | Encoding has no defined meaning |
| op_sel | output | 33 | One-hot operation select |
| mem_size | output | 2 | Access size: 0 byte, 1 half, 2 word, 3 none |

## Verification
A sweep of all 256 values of the upper byte, each with a random lower byte, covers every class-1 opcode once. This separates the reserved holes and the top boundary at 0x39/0x3A from the legal opcodes, and it separates the opcodes that take an extension word from those that do not. Random halfwords cover all three classes with varied register and immediate bits, which shows whether fields are pulled from the right positions. Directed branch offsets at the most negative, most positive and zero values show whether sign extension and doubling are correct. Class-3 conditions 9 and 10 mark the legality edge for branches.

// File: rtl/insn_decoder.sv
module insn_decoder #(
  parameter int DATA_W = 32
) (
  input  logic [15:0]       insn,
  output logic [1:0]        fmt,
  output logic [7:0]        opcode,
  output logic [3:0]        ra,
  output logic [3:0]        rb,
  output logic [DATA_W-1:0] imm,
  output logic              has_ext,
  output logic [2:0]        len,
  output logic              illegal,
  output logic [32:0]       op_sel,
  output logic [1:0]        mem_size
);
  localparam int OPS = 33;
  localparam logic [5:0] K_NONE = 6'd0,  K_LDI = 6'd1,  K_MOV = 6'd2,  K_CALL = 6'd3,
                         K_RET = 6'd4,   K_ADD = 6'd5,  K_SUB = 6'd6,  K_AND = 6'd7,
                         K_OR = 6'd8,    K_XOR = 6'd9,  K_NOT = 6'd10, K_NEG = 6'd11,
                         K_SHL = 6'd12,  K_SHR = 6'd13, K_ASR = 6'd14, K_MUL = 6'd15,
                         K_DIV = 6'd16,  K_UDIV = 6'd17, K_MOD = 6'd18, K_UMOD = 6'd19,
                         K_LD = 6'd20,   K_ST = 6'd21,  K_PUSH = 6'd22, K_POP = 6'd23,
                         K_CMP = 6'd24,  K_JMP = 6'd25, K_SWI = 6'd26, K_BRK = 6'd27,
                         K_F2 = 6'd28,   K_BR = 6'd32;
  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_NONE = 2'd3;

  logic [5:0] kind;
  logic       ext1, bad;
  logic [1:0] sz;

  assign fmt = !insn[15] ? 2'd1 : (insn[14] ? 2'd3 : 2'd2);

  always_comb begin
    kind = K_NONE;
    ext1 = 1'b0;
    bad  = 1'b0;
    sz   = SZ_NONE;
    unique case (fmt)
      2'd1: begin
        case (insn[15:8])
          8'h00: kind = K_NONE;
          8'h01: begin kind = K_LDI;  ext1 = 1'b1; end
          8'h02: kind = K_MOV;
          8'h03: begin kind = K_CALL; ext1 = 1'b1; sz = SZ_W; end
          8'h04: begin kind = K_RET;  sz = SZ_W; end
          8'h05: kind = K_ADD;
          8'h06: begin kind = K_PUSH; sz = SZ_W; end
          8'h07: begin kind = K_POP;  sz = SZ_W; end
          8'h08: begin kind = K_LD;   ext1 = 1'b1; sz = SZ_W; end
          8'h09: begin kind = K_ST;   ext1 = 1'b1; sz = SZ_W; end
          8'h0A: begin kind = K_LD;   sz = SZ_W; end
          8'h0B: begin kind = K_ST;   sz = SZ_W; end
          8'h0C: begin kind = K_LD;   ext1 = 1'b1; sz = SZ_W; end
          8'h0D: begin kind = K_ST;   ext1 = 1'b1; sz = SZ_W; end
          8'h0E: kind = K_CMP;
          8'h19: begin kind = K_CALL; sz = SZ_W; end
          8'h1A: begin kind = K_JMP;  ext1 = 1'b1; end
          8'h1B: begin kind = K_LDI;  ext1 = 1'b1; end
          8'h1C: begin kind = K_LD;   sz = SZ_B; end
          8'h1D: begin kind = K_LD;   ext1 = 1'b1; sz = SZ_B; end
          8'h1E: begin kind = K_ST;   sz = SZ_B; end
          8'h1F: begin kind = K_ST;   ext1 = 1'b1; sz = SZ_B; end
          8'h20: begin kind = K_LDI;  ext1 = 1'b1; end
          8'h21: begin kind = K_LD;   sz = SZ_H; end
          8'h22: begin kind = K_LD;   ext1 = 1'b1; sz = SZ_H; end
          8'h23: begin kind = K_ST;   sz = SZ_H; end
          8'h24: begin kind = K_ST;   ext1 = 1'b1; sz = SZ_H; end
          8'h25: kind = K_JMP;
          8'h26: kind = K_AND;
          8'h27: kind = K_SHR;
          8'h28: kind = K_SHL;
          8'h29: kind = K_SUB;
          8'h2A: kind = K_NEG;
          8'h2B: kind = K_OR;
          8'h2C: kind = K_NOT;
          8'h2D: kind = K_ASR;
          8'h2E: kind = K_XOR;
          8'h2F: kind = K_MUL;
          8'h30: begin kind = K_SWI;  ext1 = 1'b1; end
          8'h31: kind = K_DIV;
          8'h32: kind = K_UDIV;
          8'h33: kind = K_MOD;
          8'h34: kind = K_UMOD;
          8'h35: kind = K_BRK;
          8'h36: begin kind = K_LD;   ext1 = 1'b1; sz = SZ_B; end
          8'h37: begin kind = K_ST;   ext1 = 1'b1; sz = SZ_B; end
          8'h38: begin kind = K_LD;   ext1 = 1'b1; sz = SZ_H; end
          8'h39: begin kind = K_ST;   ext1 = 1'b1; sz = SZ_H; end
          default: bad = 1'b1;
        endcase
      end
      2'd2: kind = K_F2 + {4'd0, insn[13:12]};
      2'd3: begin
        if (insn[13:10] > 4'd9) bad = 1'b1;
        else kind = K_BR;
      end
      default: bad = 1'b1;
    endcase
  end

  assign illegal  = bad;
  assign has_ext  = ext1 & ~bad;
  assign len      = has_ext ? 3'd6 : 3'd2;
  assign mem_size = sz;

  always_comb begin
    op_sel = '0;
    op_sel[kind] = 1'b1;
  end

  always_comb begin
    unique case (fmt)
      2'd1: begin
        opcode = insn[15:8];
        ra     = insn[7:4];
        rb     = insn[3:0];
        imm    = '0;
      end
      2'd2: begin
        opcode = {6'd0, insn[13:12]};
        ra     = insn[11:8];
        rb     = 4'd0;
        imm    = {{(DATA_W-8){1'b0}}, insn[7:0]};
      end
      default: begin
        opcode = {4'd0, insn[13:10]};
        ra     = 4'd0;
        rb     = 4'd0;
        imm    = {{(DATA_W-11){insn[9]}}, insn[9:0], 1'b0};
      end
    endcase
  end

  always_comb begin
    if (!$isunknown(insn)) begin
      AST_ONE_OP: assert ($countones(op_sel) == 1); // R7
      AST_LEN_MATCH: assert (len == (has_ext ? 3'd6 : 3'd2)); // R6
      AST_BAD_IS_NOP: assert (!illegal || (op_sel[0] && !has_ext && mem_size == SZ_NONE)); // R5
      AST_BRANCH_SHORT: assert (fmt != 2'd3 || (!has_ext && mem_size == SZ_NONE)); // R4
      AST_F2_LEGAL: assert (fmt != 2'd2 || (!illegal && op_sel[OPS-5 +: 4] != 4'd0)); // R3
    end
  end
endmodule

// File: tb/insn_decoder_bench.sv
`timescale 1ns/1ps
module insn_decoder_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] insn;
  logic [1:0]  fmt, mem_size;
  logic [7:0]  opcode;
  logic [3:0]  ra, rb;
  logic [31:0] imm;
  logic        has_ext, illegal;
  logic [2:0]  len;
  logic [32:0] op_sel;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  insn_decoder u_insn_decoder (
    .insn(insn), .fmt(fmt), .opcode(opcode), .ra(ra), .rb(rb), .imm(imm),
    .has_ext(has_ext), .len(len), .illegal(illegal), .op_sel(op_sel), .mem_size(mem_size)
  );

  function automatic bit e_bad(logic [15:0] w);
    if (!w[15]) return (w[15:8] inside {[8'h0F:8'h18]}) || w[15:8] > 8'h39;
    if (w[14])  return w[13:10] > 4'd9;
    return 1'b0;
  endfunction

  function automatic bit e_ext(logic [15:0] w);
    if (w[15] || e_bad(w)) return 1'b0;
    return w[15:8] inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B, 8'h1D,
                           8'h1F, 8'h20, 8'h22, 8'h24, 8'h30, [8'h36:8'h39]};
  endfunction

  function automatic logic [1:0] e_sz(logic [15:0] w);
    logic [7:0] o = w[15:8];
    if (w[15] || e_bad(w)) return 2'd3;
    if (o inside {[8'h1C:8'h1F], 8'h36, 8'h37}) return 2'd0;
    if (o inside {[8'h21:8'h24], 8'h38, 8'h39}) return 2'd1;
    if (o inside {[8'h03:8'h04], [8'h06:8'h0D], 8'h19}) return 2'd2;
    return 2'd3;
  endfunction

  function automatic int e_kind(logic [15:0] w);
    logic [7:0] o = w[15:8];
    if (e_bad(w)) return 0;
    if (w[15]) return w[14] ? 32 : 28 + int'(w[13:12]);
    if (o inside {8'h01, 8'h1B, 8'h20}) return 1;
    if (o inside {8'h03, 8'h19}) return 3;
    if (o inside {8'h08, 8'h0A, 8'h0C, 8'h1C, 8'h1D, 8'h21, 8'h22, 8'h36, 8'h38}) return 20;
    if (o inside {8'h09, 8'h0B, 8'h0D, 8'h1E, 8'h1F, 8'h23, 8'h24, 8'h37, 8'h39}) return 21;
    if (o inside {8'h1A, 8'h25}) return 25;
    case (o)
      8'h02: return 2;  8'h04: return 4;  8'h05: return 5;  8'h06: return 22;
      8'h07: return 23; 8'h0E: return 24; 8'h26: return 7;  8'h27: return 13;
      8'h28: return 12; 8'h29: return 6;  8'h2A: return 11; 8'h2B: return 8;
      8'h2C: return 10; 8'h2D: return 14; 8'h2E: return 9;  8'h2F: return 15;
      8'h30: return 26; 8'h31: return 16; 8'h32: return 17; 8'h33: return 18;
      8'h34: return 19; 8'h35: return 27;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [32:0] act, logic [32:0] exp, logic [15:0] w);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s insn=%h actual=%h expected=%h", tag, w, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] w);
    logic [1:0] ef;
    logic [7:0] eop;
    logic [3:0] ea, eb;
    logic [31:0] ei;
    @(posedge clk);
    insn = w;
    @(negedge clk);
    ef = !w[15] ? 2'd1 : (w[14] ? 2'd3 : 2'd2);
    if (ef == 2'd1)      begin eop = w[15:8]; ea = w[7:4]; eb = w[3:0]; ei = 32'd0; end
    else if (ef == 2'd2) begin eop = {6'd0, w[13:12]}; ea = w[11:8]; eb = 4'd0; ei = {24'd0, w[7:0]}; end
    else begin eop = {4'd0, w[13:10]}; ea = 4'd0; eb = 4'd0;
               ei = 32'(signed'({w[9:0], 1'b0})); end
    chk("R1 fmt", 33'(fmt), 33'(ef), w);
    chk(ef == 2'd1 ? "R2 fields" : (ef == 2'd2 ? "R3 fields" : "R4 fields"),
        {opcode, ra, rb, 17'd0}, {eop, ea, eb, 17'd0}, w);
    chk(ef == 2'd1 ? "R2 imm" : (ef == 2'd2 ? "R3 imm" : "R4 imm"), 33'(imm), 33'(ei), w);
    chk("R5 illegal", 33'(illegal), 33'(e_bad(w)), w);
    chk("R6 ext/len", {29'd0, has_ext, len}, {29'd0, e_ext(w), (e_ext(w) ? 3'd6 : 3'd2)}, w);
    chk("R7 op_sel", op_sel, 33'd1 << e_kind(w), w);
    chk("R8 mem_size", 33'(mem_size), 33'(e_sz(w)), w);
  endtask

  initial begin
    int unused;
    insn = 16'h0000;
    unused = $urandom(32'd24601);
    apply(16'h0000);                                    // R7 idle encoding is a no-op
    for (int o = 0; o < 256; o++) apply({o[7:0], 8'($urandom)}); // R5 R6 R8 full opcode sweep
    apply(16'hC200); apply(16'hC1FF); apply(16'hC000);   // R4 offset extremes and zero
    apply(16'hE400); apply(16'hE800);                    // R5 condition 9 legal, 10 illegal
    apply(16'hBAFF); apply(16'h8F01);                    // R3 top immediate, inc
    apply(16'h3500); apply(16'h3A00); apply(16'h0E21);   // R7 breakpoint, R5 edge, compare
    for (int i = 0; i < 3000; i++) apply(16'($urandom));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule